// File: doc/BRIEF.md
# DMA Channel Address Generator

This block is the address and count datapath of one general-purpose DMA channel. Software programs a base word address, a page, an extended page and a transfer count through a narrow write port. Every write to a base field also loads the matching working copy. Each step strobe marks one completed transfer. On each step the working address moves by one transfer unit and the working count drops by one. The 28-bit system memory address is built from the word, page and extended-page fields.

Four mode inputs set the behaviour. Width selects byte or word transfers. Enhanced addressing lets carries and borrows ripple through every field and uses a 24-bit count; without it only the word field moves and only 16 count bits are used. A direction bit makes the address count down. Auto-initialize reloads the working copies from the base copies at terminal count. The mode inputs are captured only while the channel is idle, so a transfer in progress keeps its configuration. A channel built without enhanced capability always runs normal byte transfers.

Top module: `dmag_channel`

## Requirements
- R1: While and after reset, with no writes, `addr_o`, `count_o` and `tc_o` read zero, and the captured mode is normal, byte width, upward, auto-initialize off.
- R2: A write with select 0 loads the word field from `wr_data_i[15:0]`, select 1 loads the page from `[7:0]`, select 2 loads the extended page from `[3:0]`, and select 3 loads the 24-bit count. Each write sets both the base and the working copy and leaves the other fields alone. A step in the same cycle as a write is ignored.
- R3: At byte width the address is {extended page, page, word}, with the word field in bits 15..0.
- R4: At word width bit 0 is zero, the word field sits in bits 16..1, page bits 7..1 sit in bits 23..17, and the extended page sits in bits 27..24.
- R5: In normal mode a step adds one to the word field, or subtracts one when direction is down. The field wraps within 16 bits, and the page and extended page never change.
- R6: In enhanced mode a step moves the whole unit address by one. At byte width the unit address is 28 bits; at word width it is 27 bits, with page bit 0 left out. Carries and borrows reach the page and extended page.
- R7: Each step lowers the count by one. In enhanced mode all 24 bits count and `count_o` shows all of them. In normal mode only the low 16 bits count and are tested, and `count_o` shows them with zero upper bits.
- R8: A step taken with the count at zero is terminal. `tc_o` is high for the next cycle only. Without auto-initialize the address still advances and the count wraps to all ones (0xFFFF normal, 0xFFFFFF enhanced).
- R9: With auto-initialize on, a terminal step reloads the working address and count from the base copies instead of advancing them.
- R10: The channel becomes busy on a non-terminal step and idle on a terminal step or on any write. The mode inputs are captured only while idle; changes made while busy have no effect until the channel is idle again.
- R11: A channel whose number is not 3, 5, 6 or 7 ignores the enhanced and width inputs and always runs normal byte transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Field select: 0 word, 1 page, 2 extended page, 3 count |
| wr_data_i | input | 24 | Write data, low bits used per field |
| step_i | input | 1 | One transfer completed |
| enh_i | input | 1 | Enhanced addressing request |
| width16_i | input | 1 | Word width request |
| down_i | input | 1 | Address counts downward |
| autoinit_i | input | 1 | Reload from base on terminal count |
| addr_o | output | 28 | Current system memory address |
| count_o | output | 24 | Remaining count in transfer units |
| tc_o | output | 1 | Terminal count pulse |

## Verification
On every cycle the assertions check four things: terminal-count pulses follow a step taken at zero count, bit 0 is low at word width, the page fields hold while a normal-mode transfer is busy, and the captured mode stays fixed while busy. They also check that the enhanced count drops by exactly one per non-terminal step. Only the bench scenarios can show the exact address values: the field layout at each width, wrap and borrow at field boundaries, reload values under auto-initialize, write priority over a step, and the fixed behaviour of a channel without enhanced capability.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

    localparam int WORD_W = 16;
    localparam int PAGE_W = 8;
    localparam int EXT_W  = 4;
    localparam int ADDR_W = WORD_W + PAGE_W + EXT_W;
    localparam int CNT_W  = 24;
    localparam int NCNT_W = WORD_W;
    localparam int UNIT8_W  = ADDR_W;
    localparam int UNIT16_W = ADDR_W - 1;

    typedef enum logic [1:0] {
        SEL_WORD  = 2'd0,
        SEL_PAGE  = 2'd1,
        SEL_EXT   = 2'd2,
        SEL_COUNT = 2'd3
    } dmag_sel_e;

    typedef struct packed {
        logic enh;
        logic w16;
        logic down;
        logic autoinit;
    } dmag_cfg_t;

    typedef struct packed {
        logic [EXT_W-1:0]  ext;
        logic [PAGE_W-1:0] page;
        logic [WORD_W-1:0] word;
    } dmag_addr_t;

    function automatic logic is_enh_channel(input int id);
        return (id == 3) || (id == 5) || (id == 6) || (id == 7);
    endfunction

    function automatic logic [ADDR_W-1:0] compose(input dmag_addr_t f, input logic w16);
        if (w16)
            return {f.ext, f.page[PAGE_W-1:1], f.word, 1'b0};
        return {f.ext, f.page, f.word};
    endfunction

    function automatic dmag_addr_t advance(input dmag_addr_t f, input logic enh,
                                           input logic w16, input logic down);
        dmag_addr_t r;
        logic [UNIT8_W-1:0]  u8;
        logic [UNIT16_W-1:0] u16;
        r = f;
        if (!enh) begin
            r.word = down ? f.word - 1'b1 : f.word + 1'b1;
        end else if (!w16) begin
            u8 = {f.ext, f.page, f.word};
            u8 = down ? u8 - 1'b1 : u8 + 1'b1;
            {r.ext, r.page, r.word} = u8;
        end else begin
            u16 = {f.ext, f.page[PAGE_W-1:1], f.word};
            u16 = down ? u16 - 1'b1 : u16 + 1'b1;
            {r.ext, r.page[PAGE_W-1:1], r.word} = u16;
        end
        return r;
    endfunction

endpackage

// File: rtl/dmag_cfg_sample.sv
module dmag_cfg_sample
    import dmag_pkg::*;
#(
    parameter bit ENH_OK = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enh_i,
    input  logic      width16_i,
    input  logic      down_i,
    input  logic      autoinit_i,
    input  logic      wr_en_i,
    input  logic      step_i,
    input  logic      tc_hit_i,
    output dmag_cfg_t cfg_o,
    output logic      busy_o
);

    dmag_cfg_t req;
    dmag_cfg_t cfg_q;
    logic      busy_q;

    generate
        if (ENH_OK) begin : g_full
            assign req.enh = enh_i;
            assign req.w16 = width16_i;
        end else begin : g_fixed
            assign req.enh = 1'b0;
            assign req.w16 = 1'b0;
        end
    endgenerate

    assign req.down     = down_i;
    assign req.autoinit = autoinit_i;

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= 1'b0;
        else if (wr_en_i)
            busy_q <= 1'b0;
        else if (step_i)
            busy_q <= !tc_hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (!busy_q)
            cfg_q <= req;
    end

    assign cfg_o  = cfg_q;
    assign busy_o = busy_q;

endmodule

// File: rtl/dmag_addr_path.sv
module dmag_addr_path
    import dmag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  dmag_sel_e         wr_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              step_go_i,
    input  logic              reload_i,
    input  logic              enh_i,
    input  logic              w16_i,
    input  logic              down_i,
    output logic [ADDR_W-1:0] addr_o
);

    dmag_addr_t base_q;
    dmag_addr_t cur_q;
    dmag_addr_t stepped;

    assign stepped = advance(cur_q, enh_i, w16_i, down_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_WORD: begin
                    base_q.word <= wr_data_i;
                    cur_q.word  <= wr_data_i;
                end
                SEL_PAGE: begin
                    base_q.page <= wr_data_i[PAGE_W-1:0];
                    cur_q.page  <= wr_data_i[PAGE_W-1:0];
                end
                SEL_EXT: begin
                    base_q.ext <= wr_data_i[EXT_W-1:0];
                    cur_q.ext  <= wr_data_i[EXT_W-1:0];
                end
                default: ;
            endcase
        end else if (step_go_i) begin
            cur_q <= reload_i ? base_q : stepped;
        end
    end

    assign addr_o = compose(cur_q, w16_i);

endmodule

// File: rtl/dmag_count_path.sv
module dmag_count_path
    import dmag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_go_i,
    input  logic             enh_i,
    input  logic             autoinit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);

    localparam int HI_W = CNT_W - NCNT_W;

    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] dec_val;

    assign zero_o = enh_i ? (cur_q == '0) : (cur_q[NCNT_W-1:0] == '0);

    always_comb begin
        if (enh_i)
            dec_val = cur_q - 1'b1;
        else
            dec_val = {cur_q[CNT_W-1:NCNT_W], cur_q[NCNT_W-1:0] - 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load_i) begin
            base_q <= load_val_i;
            cur_q  <= load_val_i;
        end else if (step_go_i) begin
            cur_q <= (zero_o && autoinit_i) ? base_q : dec_val;
        end
    end

    assign count_o = enh_i ? cur_q : {{HI_W{1'b0}}, cur_q[NCNT_W-1:0]};

endmodule

// File: rtl/dmag_channel.sv
module dmag_channel
    import dmag_pkg::*;
#(
    parameter int CHAN_ID = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              step_i,
    input  logic              enh_i,
    input  logic              width16_i,
    input  logic              down_i,
    input  logic              autoinit_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              tc_o
);

    localparam bit ENH_OK = is_enh_channel(CHAN_ID);

    dmag_cfg_t cfg_q;
    dmag_sel_e sel;
    logic      busy_q;
    logic      cnt_zero;
    logic      step_go;
    logic      tc_hit;
    logic      reload;
    logic      cnt_load;
    logic      tc_q;

    assign sel      = dmag_sel_e'(wr_sel_i);
    assign step_go  = step_i && !wr_en_i;
    assign tc_hit   = step_go && cnt_zero;
    assign reload   = tc_hit && cfg_q.autoinit;
    assign cnt_load = wr_en_i && (sel == SEL_COUNT);

    dmag_cfg_sample #(.ENH_OK(ENH_OK)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .enh_i      (enh_i),
        .width16_i  (width16_i),
        .down_i     (down_i),
        .autoinit_i (autoinit_i),
        .wr_en_i    (wr_en_i),
        .step_i     (step_i),
        .tc_hit_i   (tc_hit),
        .cfg_o      (cfg_q),
        .busy_o     (busy_q)
    );

    dmag_addr_path u_addr (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (sel),
        .wr_data_i (wr_data_i[WORD_W-1:0]),
        .step_go_i (step_go),
        .reload_i  (reload),
        .enh_i     (cfg_q.enh),
        .w16_i     (cfg_q.w16),
        .down_i    (cfg_q.down),
        .addr_o    (addr_o)
    );

    dmag_count_path u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (wr_data_i),
        .step_go_i  (step_go),
        .enh_i      (cfg_q.enh),
        .autoinit_i (cfg_q.autoinit),
        .count_o    (count_o),
        .zero_o     (cnt_zero)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tc_q <= 1'b0;
        else
            tc_q <= tc_hit;
    end

    assign tc_o = tc_q;

endmodule

// File: rtl/dmag_channel_chk.sv
module dmag_channel_chk
    import dmag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en_i,
    input logic              step_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              tc_o,
    input logic              busy,
    input dmag_cfg_t         cfg,
    input logic              zero
);

    a_r8_tc_after_zero_step: assert property (@(posedge clk) disable iff (rst)
        tc_o |-> $past(step_i && !wr_en_i && zero))
        else $error("R8: tc_o without a terminal step");

    a_r4_a0_low: assert property (@(posedge clk) disable iff (rst)
        cfg.w16 |-> !addr_o[0])
        else $error("R4: address bit 0 set at word width");

    a_r5_page_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_en_i && !cfg.enh && !(step_i && zero)) |=> $stable(addr_o[ADDR_W-1:WORD_W+1]))
        else $error("R5: page fields moved in normal mode");

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg))
        else $error("R10: mode changed while busy");

    a_r7_enh_count_dec: assert property (@(posedge clk) disable iff (rst)
        (busy && step_i && !wr_en_i && !zero && cfg.enh) |=> (count_o == $past(count_o) - 1'b1))
        else $error("R7: enhanced count did not drop by one");

endmodule

bind dmag_channel dmag_channel_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en_i),
    .step_i  (step_i),
    .addr_o  (addr_o),
    .count_o (count_o),
    .tc_o    (tc_o),
    .busy    (busy_q),
    .cfg     (cfg_q),
    .zero    (cnt_zero)
);

// File: tb/dmag_channel_tb.sv
`timescale 1ns/1ps
module dmag_channel_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [23:0] wr_data = '0;
    logic        step = 1'b0;
    logic        enh = 1'b0;
    logic        w16 = 1'b0;
    logic        down = 1'b0;
    logic        autoinit = 1'b0;
    logic [27:0] addr, addr_f;
    logic [23:0] cnt, cnt_f;
    logic        tc, tc_f;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dmag_channel #(.CHAN_ID(5)) u_dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .step_i(step), .enh_i(enh), .width16_i(w16), .down_i(down), .autoinit_i(autoinit),
        .addr_o(addr), .count_o(cnt), .tc_o(tc)
    );

    dmag_channel #(.CHAN_ID(1)) u_fix (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .step_i(step), .enh_i(enh), .width16_i(w16), .down_i(down), .autoinit_i(autoinit),
        .addr_o(addr_f), .count_o(cnt_f), .tc_o(tc_f)
    );

    // {wr, sel, data, step, exp_addr, exp_cnt, exp_tc}; normal byte width, upward
    localparam int NV = 11;
    localparam logic [80:0] TBL [NV] = '{
        {1'b1, 2'd0, 24'h00FFFE, 1'b0, 28'h000FFFE, 24'h000000, 1'b0},
        {1'b1, 2'd1, 24'h000012, 1'b0, 28'h012FFFE, 24'h000000, 1'b0},
        {1'b1, 2'd2, 24'h000003, 1'b0, 28'h312FFFE, 24'h000000, 1'b0},
        {1'b1, 2'd3, 24'h000002, 1'b0, 28'h312FFFE, 24'h000002, 1'b0},
        {1'b0, 2'd0, 24'h000000, 1'b1, 28'h312FFFF, 24'h000001, 1'b0},
        {1'b0, 2'd0, 24'h000000, 1'b1, 28'h3120000, 24'h000000, 1'b0},
        {1'b0, 2'd0, 24'h000000, 1'b1, 28'h3120001, 24'h00FFFF, 1'b1},
        {1'b0, 2'd0, 24'h000000, 1'b0, 28'h3120001, 24'h00FFFF, 1'b0},
        {1'b1, 2'd3, 24'h010005, 1'b0, 28'h3120001, 24'h000005, 1'b0},
        {1'b0, 2'd0, 24'h000000, 1'b1, 28'h3120002, 24'h000004, 1'b0},
        {1'b1, 2'd0, 24'h000100, 1'b1, 28'h3120100, 24'h000004, 1'b0}
    };

    task automatic apply(input logic w, input logic [1:0] s, input logic [23:0] d, input logic st);
        wr_en = w; wr_sel = s; wr_data = d; step = st;
        @(negedge clk);
        wr_en = 1'b0; step = 1'b0;
    endtask

    task automatic chk(input string req, input logic [27:0] ea, input logic [23:0] ec, input logic et);
        checks++;
        if (addr !== ea || cnt !== ec || tc !== et) begin
            errors++;
            $display("FAIL %s: addr=%h cnt=%h tc=%b expected addr=%h cnt=%h tc=%b",
                     req, addr, cnt, tc, ea, ec, et);
        end
    endtask

    task automatic chk_fix(input string req, input logic [27:0] ea, input logic [23:0] ec, input logic et);
        checks++;
        if (addr_f !== ea || cnt_f !== ec || tc_f !== et) begin
            errors++;
            $display("FAIL %s: addr=%h cnt=%h tc=%b expected addr=%h cnt=%h tc=%b",
                     req, addr_f, cnt_f, tc_f, ea, ec, et);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 28'h0, 24'h0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 28'h0, 24'h0, 1'b0);
        chk_fix("R1 fixed channel", 28'h0, 24'h0, 1'b0);

        // table: R2 writes and priority, R3 layout, R5 wrap, R7 low count, R8 terminal
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i][80], TBL[i][79:78], TBL[i][77:54], TBL[i][53]);
            chk($sformatf("R2 R3 R5 R7 R8 vector %0d", i), TBL[i][52:25], TBL[i][24:1], TBL[i][0]);
        end

        // R4 word layout, captured while idle
        w16 = 1'b1;
        apply(1'b0, 2'd0, 24'h0, 1'b0);
        chk("R4 word layout", 28'h3120200, 24'h000004, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b1);
        chk("R4 word step", 28'h3120202, 24'h000003, 1'b0);

        // R10 mode change while busy has no effect
        w16 = 1'b0;
        apply(1'b0, 2'd0, 24'h0, 1'b0);
        chk("R10 busy keeps width", 28'h3120202, 24'h000003, 1'b0);
        apply(1'b1, 2'd3, 24'h000007, 1'b0);
        chk("R10 write ends busy", 28'h3120202, 24'h000007, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b0);
        chk("R10 new width when idle", 28'h3120101, 24'h000007, 1'b0);

        // R5 downward wrap at word width
        w16 = 1'b1; down = 1'b1;
        apply(1'b1, 2'd0, 24'h000000, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b1);
        chk("R5 down wrap", 28'h313FFFE, 24'h000006, 1'b0);

        // R6 enhanced byte carry into page and extended page, R8 24-bit wrap
        enh = 1'b1; w16 = 1'b0; down = 1'b0;
        apply(1'b1, 2'd0, 24'h00FFFF, 1'b0);
        apply(1'b1, 2'd1, 24'h0000FF, 1'b0);
        apply(1'b1, 2'd2, 24'h000002, 1'b0);
        apply(1'b1, 2'd3, 24'h000000, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b0);
        chk("R6 enhanced setup", 28'h2FFFFFF, 24'h000000, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b1);
        chk("R6 R8 enhanced carry and wrap", 28'h3000000, 24'hFFFFFF, 1'b1);

        // R6 enhanced word borrow, R7 24-bit decrement
        w16 = 1'b1; down = 1'b1;
        apply(1'b0, 2'd0, 24'h0, 1'b0);
        chk("R6 enhanced word layout", 28'h3000000, 24'hFFFFFF, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b1);
        chk("R6 R7 enhanced borrow", 28'h2FFFFFE, 24'hFFFFFE, 1'b0);

        // R9 auto-initialize reload
        enh = 1'b0; w16 = 1'b0; down = 1'b0; autoinit = 1'b1;
        apply(1'b1, 2'd0, 24'h000010, 1'b0);
        apply(1'b1, 2'd3, 24'h000001, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b0);
        chk("R9 setup", 28'h2FE0010, 24'h000001, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b1);
        chk("R9 step", 28'h2FE0011, 24'h000000, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b1);
        chk("R9 reload", 28'h2FF0010, 24'h000001, 1'b1);

        // R11 fixed channel ignores enhanced and width requests
        autoinit = 1'b0; enh = 1'b1; w16 = 1'b1;
        apply(1'b1, 2'd0, 24'h00FFFF, 1'b0);
        apply(1'b1, 2'd1, 24'h000040, 1'b0);
        apply(1'b1, 2'd2, 24'h000001, 1'b0);
        apply(1'b1, 2'd3, 24'h000000, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b0);
        chk("R11 capable channel layout", 28'h141FFFE, 24'h000000, 1'b0);
        chk_fix("R11 fixed channel layout", 28'h140FFFF, 24'h000000, 1'b0);
        apply(1'b0, 2'd0, 24'h0, 1'b1);
        chk("R11 capable channel carry", 28'h1420000, 24'hFFFFFF, 1'b1);
        chk_fix("R11 fixed channel wrap", 28'h1400000, 24'h00FFFF, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule